// File: doc/BRIEF.md
# Answer-to-Reset Serial Bit Streamer

This block answers a reset pulse from a card reader with a fixed identification word, sent one bit per serial clock. The host holds chip select low and pulses the reset line high. Once the pulse ends, the block drives the first bit of the word. Each falling edge of the serial clock then moves the output on to the next bit. The word is a build-time mask parameter made of bytes. Byte 0 goes out first, and each byte goes out least significant bit first. After the last bit the sequence begins again at byte 0 and keeps looping for as long as clocks arrive.

Three conditions keep the stream from starting or end it:
- Chip select going high returns the block to standby at once.
- A pending nonvolatile write, flagged by a busy input, blocks any start.
- A second reset pulse while streaming halts the output. The output stays released until chip select goes high.

While the block is not streaming, the data output is released: the enable is low and the data bit reads 0. All pins are sampled on the system clock, so each pin must stay at one level for at least one system clock.

Top module: `atr_streamer`

## Requirements
- R1: After the system reset `rstN`, `dataOe` is 0 and `dataOut` is 0.
- R2: A start needs `rstPin` to rise and then fall while `csN` is 0. From the system clock edge that samples the fall, `dataOe` is 1 and `dataOut` carries bit 0 of byte 0.
- R3: Stream position k carries bit (k mod 8) of byte (k div 8). Byte n is held in bits [8n+7:8n] of `ATR_VALUE`. The default value is 32'h55AA0119, so the bytes go out as 19h, 01h, AAh, 55h.
- R4: While streaming, each falling edge of `sclIn` advances the output by one position, and a rising edge leaves it unchanged.
- R5: After position 31 the next falling edge returns the output to position 0 (bit 0 of byte 0), and the loop continues without limit.
- R6: `csN` at 1 clears `dataOe` on the next sampling edge, from any state. A reset pulse while `csN` is 1 starts nothing.
- R7: If `wrBusy` is 1 when `rstPin` rises or when it falls, no stream starts and `dataOe` stays 0.
- R8: A rise of `rstPin` while streaming clears `dataOe`. Further reset pulses are then ignored until `csN` has been 1 for at least one sampling edge.
- R9: Whenever `dataOe` is 0, `dataOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rstN | input | 1 | Active-low system reset, asynchronous |
| csN | input | 1 | Chip select, active low |
| rstPin | input | 1 | Reset-request pulse from the reader |
| sclIn | input | 1 | Serial clock from the reader |
| wrBusy | input | 1 | High while a nonvolatile write is in progress |
| dataOut | output | 1 | Current stream bit, 0 when released |
| dataOe | output | 1 | Output enable for the data pad |

## Verification
The assertions take for granted that every pin is already synchronous to the system clock and holds each level for at least one sampling edge. On that basis a rise of `rstPin` matches `$rose` on the sampled pin, and the serial clock never skips an edge between samples. The stimulus changes pins only on the falling edge of the system clock. It keeps every serial-clock high and low phase, and every reset-pulse phase, at least one full system clock long.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_STREAM = 2'd2,
    ST_HALT   = 2'd3
  } atrState_t;

  typedef struct packed {
    logic start;
    logic step;
    logic stop;
  } atrStrobe_t;
endpackage

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rstPin,
  input  logic       sclIn,
  input  logic       wrBusy,
  output atrStrobe_t strobe
);
  atrState_t state, stateNext;
  logic rstPrev, sclPrev;
  logic rstRise, rstFall, sclFall;

  assign rstRise = rstPin & ~rstPrev;
  assign rstFall = ~rstPin & rstPrev;
  assign sclFall = ~sclIn & sclPrev;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (csN) begin
      stateNext   = ST_IDLE;
      strobe.stop = 1'b1;
    end else begin
      case (state)
        ST_IDLE:  if (rstRise && !wrBusy) stateNext = ST_ARMED;
        ST_ARMED: if (rstFall) begin
                    if (wrBusy) stateNext = ST_IDLE;
                    else begin
                      stateNext    = ST_STREAM;
                      strobe.start = 1'b1;
                    end
                  end
        ST_STREAM: if (rstRise) begin
                     stateNext   = ST_HALT;
                     strobe.stop = 1'b1;
                   end else if (sclFall) strobe.step = 1'b1;
        default: stateNext = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rstPrev <= 1'b0;
      sclPrev <= 1'b0;
    end else begin
      state   <= stateNext;
      rstPrev <= rstPin;
      sclPrev <= sclIn;
    end
  end

  // R8: once halted, only chip select high leaves the halt state
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && !csN) |=> state == ST_HALT);

  // R7: a start strobe never coincides with a pending write
  assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> !wrBusy);
endmodule

// File: rtl/atr_datapath.sv
module atr_datapath
  import atr_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter logic [BYTE_W*NUM_BYTES-1:0] ATR_VALUE = 32'h55AA0119
) (
  input  logic       clk,
  input  logic       rstN,
  input  atrStrobe_t strobe,
  output logic       dataOut,
  output logic       dataOe
);
  localparam int TOTAL  = BYTE_W * NUM_BYTES;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

  logic [IDX_W-1:0] idx;
  logic             oeReg;
  logic [NUM_BYTES-1:0] laneBit;
  logic [BIT_W-1:0] bitSel;
  logic [IDX_W-1:0] byteSel;

  assign bitSel  = BIT_W'(idx % BYTE_W);
  assign byteSel = IDX_W'(idx / BYTE_W);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gLane
    logic [BYTE_W-1:0] laneByte;
    assign laneByte   = ATR_VALUE[g*BYTE_W +: BYTE_W];
    assign laneBit[g] = laneByte[bitSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx   <= '0;
      oeReg <= 1'b0;
    end else if (strobe.stop) begin
      oeReg <= 1'b0;
    end else if (strobe.start) begin
      idx   <= '0;
      oeReg <= 1'b1;
    end else if (strobe.step) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  assign dataOe  = oeReg;
  assign dataOut = oeReg & laneBit[byteSel[$clog2(NUM_BYTES > 1 ? NUM_BYTES : 2)-1:0]];

  // R2: a fresh stream always begins at position 0
  assert_start_at_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> (idx == '0 && dataOe));

  // R5: the index wraps from the last position back to 0
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.stop && !strobe.start && idx == LAST) |=> idx == '0);
endmodule

// File: rtl/atr_streamer.sv
module atr_streamer
  import atr_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter logic [BYTE_W*NUM_BYTES-1:0] ATR_VALUE = 32'h55AA0119
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic rstPin,
  input  logic sclIn,
  input  logic wrBusy,
  output logic dataOut,
  output logic dataOe
);
  atrStrobe_t strobe;

  atr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rstPin(rstPin),
    .sclIn(sclIn), .wrBusy(wrBusy), .strobe(strobe)
  );

  atr_datapath #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ATR_VALUE(ATR_VALUE)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataOut(dataOut), .dataOe(dataOe)
  );

  // R6: chip select high releases the pad on the next edge
  assert_cs_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !dataOe);

  // R7: while busy and idle, no stream can begin
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrBusy && !dataOe) |=> !dataOe);

  // R8: a reset pulse in mid-stream releases the pad
  assert_rst_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $rose(rstPin)) |=> !dataOe);

  // R9: data is quiet while released
  always_comb begin
    if (rstN) assert_quiet_R9: assert (dataOe || !dataOut);
  end
endmodule

// File: tb/tb_atr_streamer.sv
module tb_atr_streamer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rstPin = 1'b0, sclIn = 1'b0, wrBusy = 1'b0;
  logic dataOut, dataOe;
  int checks = 0, fails = 0;
  logic [7:0] atrBytes [4] = '{8'h19, 8'h01, 8'hAA, 8'h55};

  always #5 clk = ~clk;

  atr_streamer dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rstPin(rstPin),
    .sclIn(sclIn), .wrBusy(wrBusy), .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic expBit(int k);
    int p = k % 32;
    return atrBytes[p / 8][p % 8];
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic sclClock();
    tick(); sclIn = 1'b1;
    tick(); sclIn = 1'b0;
    tick();
  endtask

  task automatic pulseRst();
    tick(); rstPin = 1'b1;
    tick(); rstPin = 1'b0;
    tick();
  endtask

  task automatic deselect();
    tick(); csN = 1'b1; tick(); tick();
  endtask

  task automatic testReset();
    check("R1 oe", dataOe, 1'b0);
    check("R1 data", dataOut, 1'b0);
  endtask

  task automatic testFullStream();
    tick(); csN = 1'b0;
    pulseRst();
    check("R2 oe after start", dataOe, 1'b1);
    check("R2 first bit", dataOut, expBit(0));
    tick(); sclIn = 1'b1; tick(); tick();
    check("R4 rise no effect", dataOut, expBit(0));
    sclIn = 1'b0; tick();
    check("R4 step to 1", dataOut, expBit(1));
    for (int k = 2; k < 44; k++) begin
      sclClock();
      if (k < 32) check("R3 stream bit", dataOut, expBit(k));
      else check("R5 wrapped bit", dataOut, expBit(k));
    end
    check("R9 oe during stream", dataOe, 1'b1);
  endtask

  task automatic testCsAbort();
    deselect();
    check("R6 cs abort", dataOe, 1'b0);
    check("R9 quiet after abort", dataOut, 1'b0);
    pulseRst();
    check("R6 no start with cs high", dataOe, 1'b0);
  endtask

  task automatic testBusy();
    tick(); csN = 1'b0; wrBusy = 1'b1;
    pulseRst();
    check("R7 busy at rise", dataOe, 1'b0);
    tick(); rstPin = 1'b1; tick(); wrBusy = 1'b0; rstPin = 1'b0; tick(); tick();
    check("R7 busy cleared mid pulse still idle", dataOe, 1'b0);
    tick(); rstPin = 1'b1; tick(); wrBusy = 1'b1; rstPin = 1'b0; tick(); tick();
    check("R7 busy at fall", dataOe, 1'b0);
    wrBusy = 1'b0;
    deselect();
  endtask

  task automatic testRstHalt();
    tick(); csN = 1'b0;
    pulseRst();
    check("R2 restart", dataOe, 1'b1);
    sclClock(); sclClock(); sclClock();
    check("R3 bit 3", dataOut, expBit(3));
    tick(); rstPin = 1'b1; tick();
    check("R8 halt on rst", dataOe, 1'b0);
    rstPin = 1'b0; tick();
    pulseRst();
    check("R8 pulse ignored while halted", dataOe, 1'b0);
    sclClock();
    check("R9 quiet while halted", dataOut, 1'b0);
    deselect();
    tick(); csN = 1'b0;
    pulseRst();
    check("R8 start after deselect", dataOe, 1'b1);
    check("R8 position zero", dataOut, expBit(0));
    deselect();
  endtask

  initial begin
    tick(); tick();
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testFullStream();
    testCsAbort();
    testBusy();
    testRstHalt();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule